// File: doc/BRIEF.md
# LUT-Driven Brightness Ramp Sequencer

This block drives the duty value of several PWM channels from one shared brightness table. Each channel has its own sequencer. A sequencer walks through a programmed window of table entries and holds each entry for a fixed number of millisecond ticks. At the two ends of the window it can add extra dwells, counted in whole steps. Each entry is presented the moment its step starts. There is no fading between entries.

A channel's walk can go upward, go downward, or bounce between the two ends. It can either loop without end or stop after one pass and keep its final entry on the output. Software programs the per-channel settings and fills the table. It then writes a channel bitmask to a shared start port, and every channel whose bit is set begins its walk. All timing comes from a one-cycle tick strobe that pulses once per millisecond.

Top module: `lut_ramp_seq`

## Requirements
- R1: After reset every channel is idle: `busy_o` and `done_o` are all zero and every duty slice is zero.
- R2: A cycle with `start_we` high launches each channel i whose bit `start_mask[i]` is set, even a channel that is already running, which restarts from its first entry. A channel whose bit is clear keeps its state.
- R3: While a channel is busy or done, its duty slice `duty_o[i*DUTY_W +: DUTY_W]` equals the table entry at its current index, from the cycle after the step begins. While it is idle the slice is zero. The slice changes only after a tick, a start, a configuration write or a table write.
- R4: Each step lasts `step` ticks; a step value of 0 behaves as 1. A tick that arrives in the same cycle as a launch is not counted.
- R5: Mode bit 4 set with bit 2 clear walks upward from the low index to the high index. With repeat (bit 3) set, it then wraps to the low index.
- R6: Mode bit 4 clear with bit 2 clear walks downward from the high index to the low index. With repeat set, it then wraps to the high index.
- R7: Mode bit 2 set bounces between the two ends. Each end entry is shown once per turn, so the walk goes up, then down, then up again.
- R8: With mode bit 1 set and a nonzero high count, a step on the high index is followed by an extra dwell of (high count × step) ticks on the same entry. A count of zero adds no dwell.
- R9: With mode bit 0 set and a nonzero low count, a step on the low index is followed by an extra dwell of (low count × step) ticks on the same entry.
- R10: With repeat clear, the channel makes one pass and then becomes done, keeping its last entry on the output.
  - In upward mode a pass ends after the high entry; in downward mode it ends after the low entry.
  - In bounce mode the pass runs out and back, and ends after the start entry is reached again.
- R11: If the low index is not below the high index, the window becomes the whole table, 0 to TBL_DEPTH-1.
- R12: A configuration write to channel i stops it (idle, duty zero, done cleared). If a launch of channel i falls in the same cycle, the launch wins.
- R13: A configuration write goes only to channel `cfg_ch`, and other channels are left untouched. The field codes on `cfg_sel` are:
  - 0: mode (5 bits, mode[4:0] = cfg_wdata[4:0]);
  - 1: low index;
  - 2: high index;
  - 3: step (9 bits);
  - 4: high count (8 bits);
  - 5: low count (8 bits).

Index fields keep the low $clog2(TBL_DEPTH) bits of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | $clog2(NUM_CH) | Channel addressed by the configuration write |
| cfg_sel | input | 3 | Field code of the configuration write |
| cfg_wdata | input | 9 | Configuration write data |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | $clog2(TBL_DEPTH) | Table write address |
| tbl_wdata | input | DUTY_W | Table write data |
| start_we | input | 1 | Shared start strobe |
| start_mask | input | NUM_CH | Channels to launch |
| duty_o | output | NUM_CH*DUTY_W | Duty per channel, channel i at slice i |
| busy_o | output | NUM_CH | Channel is stepping or pausing |
| done_o | output | NUM_CH | Channel has finished a single pass |

## Verification
Two events can land in the same cycle, and the bench provokes both. In the first, a launch and a millisecond tick arrive together. The bench raises both strobes on one edge and then counts how many further ticks pass before the first entry changes: it must take a full step, which shows the coinciding tick was dropped. In the second, a configuration write and a launch address the same channel at once. The bench expects the channel to come out busy and showing its first entry, not stopped.

// File: rtl/lut_ramp_seq_pkg.sv
package lut_ramp_seq_pkg;

  localparam int FIELD_W = 9;
  localparam int STEP_W  = 9;
  localparam int CNT_W   = 8;

  localparam logic [2:0] SEL_MODE  = 3'd0;
  localparam logic [2:0] SEL_LO    = 3'd1;
  localparam logic [2:0] SEL_HI    = 3'd2;
  localparam logic [2:0] SEL_STEP  = 3'd3;
  localparam logic [2:0] SEL_HICNT = 3'd4;
  localparam logic [2:0] SEL_LOCNT = 3'd5;

  // packed MSB first: fwd is bit 4, lo_wait is bit 0
  typedef struct packed {
    logic fwd;
    logic rpt;
    logic bounce;
    logic hi_wait;
    logic lo_wait;
  } ramp_mode_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STEP  = 2'd1,
    SEQ_PAUSE = 2'd2,
    SEQ_HOLD  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/lut_ramp_table.sv
module lut_ramp_table #(
  parameter int DEPTH    = 64,
  parameter int DUTY_W   = 9,
  parameter int RD_PORTS = 3,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DUTY_W-1:0]          wdata,
  input  logic [RD_PORTS*AW-1:0]     raddr,
  output logic [RD_PORTS*DUTY_W-1:0] rdata
);

  logic [DUTY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata[p*DUTY_W +: DUTY_W] = mem_q[raddr[p*AW +: AW]];
  end

endmodule

// File: rtl/lut_ramp_chan_cfg.sv
module lut_ramp_chan_cfg
  import lut_ramp_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  output ramp_mode_t         mode,
  output logic [AW-1:0]      lo_idx,
  output logic [AW-1:0]      hi_idx,
  output logic [STEP_W-1:0]  step_len,
  output logic [CNT_W-1:0]   hi_cnt,
  output logic [CNT_W-1:0]   lo_cnt
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  ramp_mode_t        mode_q;
  logic [AW-1:0]     lo_q, hi_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  hic_q, loc_q;

  logic en_mode, en_lo, en_hi, en_step, en_hic, en_loc;

  always_comb begin
    en_mode = wr_en && (wr_sel == SEL_MODE);
    en_lo   = wr_en && (wr_sel == SEL_LO);
    en_hi   = wr_en && (wr_sel == SEL_HI);
    en_step = wr_en && (wr_sel == SEL_STEP);
    en_hic  = wr_en && (wr_sel == SEL_HICNT);
    en_loc  = wr_en && (wr_sel == SEL_LOCNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      step_q <= '0;
      hic_q  <= '0;
      loc_q  <= '0;
    end else begin
      if (en_mode) mode_q <= ramp_mode_t'(wr_data[4:0]);
      if (en_lo)   lo_q   <= wr_data[AW-1:0];
      if (en_hi)   hi_q   <= wr_data[AW-1:0];
      if (en_step) step_q <= wr_data[STEP_W-1:0];
      if (en_hic)  hic_q  <= wr_data[CNT_W-1:0];
      if (en_loc)  loc_q  <= wr_data[CNT_W-1:0];
    end
  end

  // an empty or inverted window widens to the whole table
  always_comb begin
    mode     = mode_q;
    step_len = step_q;
    hi_cnt   = hic_q;
    lo_cnt   = loc_q;
    if (lo_q < hi_q) begin
      lo_idx = lo_q;
      hi_idx = hi_q;
    end else begin
      lo_idx = '0;
      hi_idx = LAST_IDX;
    end
  end

endmodule

// File: rtl/lut_ramp_chan_fsm.sv
module lut_ramp_chan_fsm
  import lut_ramp_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch,
  input  logic              halt,
  input  ramp_mode_t        mode,
  input  logic [AW-1:0]     lo_idx,
  input  logic [AW-1:0]     hi_idx,
  input  logic [STEP_W-1:0] step_len,
  input  logic [CNT_W-1:0]  hi_cnt,
  input  logic [CNT_W-1:0]  lo_cnt,
  output logic [AW-1:0]     idx_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [AW-1:0] IDX_ONE = AW'(1);

  seq_state_e        state_q, state_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic              up_q, up_d;
  logic [STEP_W-1:0] ms_q, ms_d;
  logic [CNT_W-1:0]  pc_q, pc_d;

  logic [STEP_W:0]   ms_inc;
  logic [CNT_W:0]    pc_inc;
  logic              step_last, at_hi, at_lo, pause_here, pause_last;
  logic [CNT_W-1:0]  pause_len;
  logic [AW-1:0]     adv_idx;
  logic              adv_up, adv_fin, seg_end;

  // dwell counters
  always_comb begin
    ms_inc     = {1'b0, ms_q} + {{STEP_W{1'b0}}, 1'b1};
    pc_inc     = {1'b0, pc_q} + {{CNT_W{1'b0}}, 1'b1};
    step_last  = tick && (ms_inc >= {1'b0, step_len});
    at_hi      = (idx_q == hi_idx);
    at_lo      = (idx_q == lo_idx);
    pause_len  = at_hi ? hi_cnt : lo_cnt;
    pause_here = (at_hi && mode.hi_wait && (hi_cnt != '0)) ||
                 (at_lo && mode.lo_wait && (lo_cnt != '0));
    pause_last = (pc_inc >= {1'b0, pause_len});
  end

  // where the walk goes after the current entry
  always_comb begin
    adv_idx = idx_q;
    adv_up  = up_q;
    adv_fin = 1'b0;
    if (mode.bounce) begin
      if (up_q) begin
        if (at_hi) begin
          if (!mode.fwd && !mode.rpt) adv_fin = 1'b1;
          else begin
            adv_up  = 1'b0;
            adv_idx = hi_idx - IDX_ONE;
          end
        end else begin
          adv_idx = idx_q + IDX_ONE;
        end
      end else begin
        if (at_lo) begin
          if (mode.fwd && !mode.rpt) adv_fin = 1'b1;
          else begin
            adv_up  = 1'b1;
            adv_idx = lo_idx + IDX_ONE;
          end
        end else begin
          adv_idx = idx_q - IDX_ONE;
        end
      end
    end else if (mode.fwd) begin
      if (at_hi) begin
        if (mode.rpt) adv_idx = lo_idx;
        else          adv_fin = 1'b1;
      end else begin
        adv_idx = idx_q + IDX_ONE;
      end
    end else begin
      if (at_lo) begin
        if (mode.rpt) adv_idx = hi_idx;
        else          adv_fin = 1'b1;
      end else begin
        adv_idx = idx_q - IDX_ONE;
      end
    end
  end

  // next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    up_d    = up_q;
    ms_d    = ms_q;
    pc_d    = pc_q;
    seg_end = 1'b0;
    if (launch) begin
      state_d = SEQ_STEP;
      idx_d   = mode.fwd ? lo_idx : hi_idx;
      up_d    = mode.fwd;
      ms_d    = '0;
      pc_d    = '0;
    end else if (halt) begin
      state_d = SEQ_IDLE;
      ms_d    = '0;
      pc_d    = '0;
    end else begin
      case (state_q)
        SEQ_STEP: begin
          if (tick) begin
            if (step_last) begin
              ms_d = '0;
              if (pause_here) begin
                state_d = SEQ_PAUSE;
                pc_d    = '0;
              end else begin
                seg_end = 1'b1;
              end
            end else begin
              ms_d = ms_inc[STEP_W-1:0];
            end
          end
        end
        SEQ_PAUSE: begin
          if (tick) begin
            if (step_last) begin
              ms_d = '0;
              if (pause_last) seg_end = 1'b1;
              else            pc_d = pc_inc[CNT_W-1:0];
            end else begin
              ms_d = ms_inc[STEP_W-1:0];
            end
          end
        end
        default: ;
      endcase
      if (seg_end) begin
        if (adv_fin) begin
          state_d = SEQ_HOLD;
        end else begin
          state_d = SEQ_STEP;
          idx_d   = adv_idx;
          up_d    = adv_up;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      up_q    <= 1'b0;
      ms_q    <= '0;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      up_q    <= up_d;
      ms_q    <= ms_d;
      pc_q    <= pc_d;
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = (state_q == SEQ_STEP) || (state_q == SEQ_PAUSE);
  assign done_o = (state_q == SEQ_HOLD);

endmodule

// File: rtl/lut_ramp_seq.sv
module lut_ramp_seq
  import lut_ramp_seq_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int TBL_DEPTH = 64,
  parameter int DUTY_W    = 9,
  localparam int AW       = $clog2(TBL_DEPTH),
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_ms,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_ch,
  input  logic [2:0]               cfg_sel,
  input  logic [FIELD_W-1:0]       cfg_wdata,
  input  logic                     tbl_we,
  input  logic [AW-1:0]            tbl_addr,
  input  logic [DUTY_W-1:0]        tbl_wdata,
  input  logic                     start_we,
  input  logic [NUM_CH-1:0]        start_mask,
  output logic [NUM_CH*DUTY_W-1:0] duty_o,
  output logic [NUM_CH-1:0]        busy_o,
  output logic [NUM_CH-1:0]        done_o
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_CH*AW-1:0]     rd_addr;
  logic [NUM_CH*DUTY_W-1:0] rd_data;

  lut_ramp_table #(
    .DEPTH    (TBL_DEPTH),
    .DUTY_W   (DUTY_W),
    .RD_PORTS (NUM_CH)
  ) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ramp_mode_t        mode;
    logic [AW-1:0]     lo_idx, hi_idx, idx;
    logic [STEP_W-1:0] step_len;
    logic [CNT_W-1:0]  hi_cnt, lo_cnt;
    logic              sel_wr, launch, busy, done;

    assign sel_wr = cfg_we && (cfg_ch == CH_W'(c));
    assign launch = start_we && start_mask[c];

    lut_ramp_chan_cfg #(.DEPTH(TBL_DEPTH)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .wr_en    (sel_wr),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .mode     (mode),
      .lo_idx   (lo_idx),
      .hi_idx   (hi_idx),
      .step_len (step_len),
      .hi_cnt   (hi_cnt),
      .lo_cnt   (lo_cnt)
    );

    lut_ramp_chan_fsm #(.DEPTH(TBL_DEPTH)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .tick     (tick_ms),
      .launch   (launch),
      .halt     (sel_wr),
      .mode     (mode),
      .lo_idx   (lo_idx),
      .hi_idx   (hi_idx),
      .step_len (step_len),
      .hi_cnt   (hi_cnt),
      .lo_cnt   (lo_cnt),
      .idx_o    (idx),
      .busy_o   (busy),
      .done_o   (done)
    );

    assign rd_addr[c*AW +: AW]         = idx;
    assign duty_o[c*DUTY_W +: DUTY_W]  = (busy || done) ? rd_data[c*DUTY_W +: DUTY_W] : '0;
    assign busy_o[c]                   = busy;
    assign done_o[c]                   = done;
  end

endmodule

// File: rtl/lut_ramp_seq_chk.sv
module lut_ramp_seq_chk #(
  parameter int NUM_CH = 3,
  parameter int DUTY_W = 9,
  parameter int CH_W   = 2
) (
  input logic                     clk,
  input logic                     rst_ok,
  input logic                     tick_ms,
  input logic                     cfg_we,
  input logic [CH_W-1:0]          cfg_ch,
  input logic                     start_we,
  input logic [NUM_CH-1:0]        start_mask,
  input logic                     tbl_we,
  input logic [NUM_CH*DUTY_W-1:0] duty_o,
  input logic [NUM_CH-1:0]        busy_o,
  input logic [NUM_CH-1:0]        done_o
);

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!tick_ms && !start_we && !cfg_we && !tbl_we) |=> $stable(duty_o));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_ok)
      (start_we && start_mask[c]) |=> (busy_o[c] && !done_o[c]));

    assert_halt_R12: assert property (@(posedge clk) disable iff (!rst_ok)
      (cfg_we && (cfg_ch == CH_W'(c)) && !(start_we && start_mask[c]))
      |=> (!busy_o[c] && !done_o[c] && (duty_o[c*DUTY_W +: DUTY_W] == '0)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_ok)
      (done_o[c] && !(start_we && start_mask[c]) && !(cfg_we && (cfg_ch == CH_W'(c))))
      |=> done_o[c]);

    assert_finish_R10: assert property (@(posedge clk) disable iff (!rst_ok)
      $rose(done_o[c]) |-> $past(busy_o[c]));
  end

endmodule

bind lut_ramp_seq lut_ramp_seq_chk #(
  .NUM_CH (NUM_CH),
  .DUTY_W (DUTY_W),
  .CH_W   (CH_W)
) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_q),
  .tick_ms    (tick_ms),
  .cfg_we     (cfg_we),
  .cfg_ch     (cfg_ch),
  .start_we   (start_we),
  .start_mask (start_mask),
  .tbl_we     (tbl_we),
  .duty_o     (duty_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/lut_ramp_seq_test.sv
module lut_ramp_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam int DEPTH  = 64;
  localparam int DW     = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [2:0] cfg_sel = '0;
  logic [8:0] cfg_wdata = '0;
  logic tbl_we = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [DW-1:0] tbl_wdata = '0;
  logic start_we = 1'b0;
  logic [NUM_CH-1:0] start_mask = '0;
  logic [NUM_CH*DW-1:0] duty_o;
  logic [NUM_CH-1:0] busy_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_ramp_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .start_we(start_we), .start_mask(start_mask),
    .duty_o(duty_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int duty(input int ch);
    return int'(duty_o[ch*DW +: DW]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tk();
    tick_ms = 1'b1;
    @(negedge clk);
    tick_ms = 1'b0;
  endtask

  task automatic cfg(input int ch, input int sel, input int val);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = 9'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strt(input int mask);
    start_we = 1'b1; start_mask = NUM_CH'(mask);
    @(negedge clk);
    start_we = 1'b0; start_mask = '0;
  endtask

  task automatic setup(input int ch, input int mode, input int lo, input int hi,
                       input int step, input int hic, input int loc);
    cfg(ch, 0, mode); cfg(ch, 1, lo); cfg(ch, 2, hi);
    cfg(ch, 3, step); cfg(ch, 4, hic); cfg(ch, 5, loc);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 duty", int'(duty_o), 0);
  endtask

  task automatic t_forward();
    setup(0, 'h18, 2, 5, 2, 0, 0);
    strt(1);
    chk("R3 first entry", duty(0), 12);
    chk("R2 ch0 busy", int'(busy_o[0]), 1);
    chk("R2 ch1 untouched", int'(busy_o[1]), 0);
    tk(); chk("R4 mid step", duty(0), 12);
    tk(); chk("R5 step up", duty(0), 13);
    tk(); tk(); chk("R5 step up", duty(0), 14);
    tk(); tk(); chk("R5 high end", duty(0), 15);
    tk(); tk(); chk("R5 wrap", duty(0), 12);
    tick_ms = 1'b1; start_we = 1'b1; start_mask = 3'b001;
    @(negedge clk);
    tick_ms = 1'b0; start_we = 1'b0; start_mask = '0;
    tk(); chk("R4 launch tick dropped", duty(0), 12);
    tk(); chk("R4 full step after launch", duty(0), 13);
    strt(1); chk("R2 restart", duty(0), 12);
    cfg(0, 3, 0); strt(1);
    tk(); chk("R4 zero step", duty(0), 13);
  endtask

  task automatic t_reverse();
    setup(1, 'h08, 2, 4, 1, 0, 0);
    strt(2);
    chk("R6 start high", duty(1), 14);
    tk(); chk("R6 down", duty(1), 13);
    tk(); chk("R6 down", duty(1), 12);
    tk(); chk("R6 wrap", duty(1), 14);
  endtask

  task automatic t_bounce();
    int exp_seq[6] = '{11, 12, 13, 12, 11, 12};
    setup(2, 'h1C, 1, 3, 1, 0, 0);
    strt(4);
    chk("R7 start", duty(2), exp_seq[0]);
    for (int k = 1; k < 6; k++) begin
      tk(); chk("R7 bounce", duty(2), exp_seq[k]);
    end
  endtask

  task automatic t_pause();
    int exp_seq[9] = '{10, 10, 11, 12, 12, 12, 10, 10, 11};
    setup(0, 'h1B, 0, 2, 1, 2, 1);
    strt(1);
    chk("R9 start", duty(0), exp_seq[0]);
    for (int k = 1; k < 9; k++) begin
      tk(); chk("R8 R9 pause walk", duty(0), exp_seq[k]);
    end
    cfg(0, 4, 0); strt(1);
    tk(); chk("R9 low pause", duty(0), 10);
    tk(); tk(); chk("R8 high reached", duty(0), 12);
    tk(); chk("R8 zero count", duty(0), 10);
  endtask

  task automatic t_single();
    int exp_seq[5] = '{13, 14, 15, 14, 13};
    setup(1, 'h10, 3, 4, 1, 0, 0);
    strt(2);
    chk("R10 start", duty(1), 13);
    tk(); chk("R10 up", duty(1), 14);
    tk();
    chk("R10 done", int'(done_o[1]), 1);
    chk("R10 not busy", int'(busy_o[1]), 0);
    chk("R10 holds", duty(1), 14);
    tk(); chk("R10 still holds", duty(1), 14);
    strt(4);
    chk("R2 cleared bit", int'(done_o[1]), 1);
    setup(1, 'h14, 3, 5, 1, 0, 0);
    strt(2);
    chk("R10 bounce start", duty(1), exp_seq[0]);
    for (int k = 1; k < 5; k++) begin
      tk(); chk("R10 bounce pass", duty(1), exp_seq[k]);
    end
    chk("R10 bounce busy", int'(busy_o[1]), 1);
    tk();
    chk("R10 bounce done", int'(done_o[1]), 1);
    chk("R10 bounce holds", duty(1), 13);
  endtask

  task automatic t_whole();
    setup(2, 'h18, 7, 7, 1, 0, 0);
    strt(4);
    chk("R11 table start", duty(2), 10);
    for (int k = 1; k < DEPTH; k++) tk();
    chk("R11 table end", duty(2), 10 + DEPTH - 1);
    tk(); chk("R11 wrap", duty(2), 10);
  endtask

  task automatic t_stop();
    cfg(0, 3, 1);
    chk("R13 other channel runs", int'(busy_o[2]), 1);
    chk("R13 target stopped", int'(busy_o[0]), 0);
    cfg(2, 5, 0);
    chk("R12 busy cleared", int'(busy_o[2]), 0);
    chk("R12 duty zero", duty(2), 0);
    cfg_we = 1'b1; cfg_ch = 2'd2; cfg_sel = 3'd5; cfg_wdata = '0;
    start_we = 1'b1; start_mask = 3'b100;
    @(negedge clk);
    cfg_we = 1'b0; start_we = 1'b0; start_mask = '0;
    chk("R12 launch wins", int'(busy_o[2]), 1);
    chk("R12 launch entry", duty(2), 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    for (int k = 0; k < DEPTH; k++) begin
      tbl_we = 1'b1; tbl_addr = 6'(k); tbl_wdata = DW'(10 + k);
      @(negedge clk);
    end
    tbl_we = 1'b0;
    t_forward();
    t_reverse();
    t_bounce();
    t_pause();
    t_single();
    t_whole();
    t_stop();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1-all actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule